// File: doc/BRIEF.md
# DDR refresh and self-refresh sequencer

This block sits on the controller side of a DDR SDRAM interface. It keeps the device refreshed and moves it into and out of self refresh. An interval timer counts the average refresh period. Each time the timer expires, a saturating count of owed refreshes goes up by one. While that count is non-zero, the block asks the main command arbiter for the command bus. The arbiter may hold off for as long as it likes until the count reaches its ceiling. At the ceiling the urgent flag rises, and the arbiter must grant at its next opportunity.

A command is placed on the pins only when the arbiter grants and the banks-precharged input is high. If the grant arrives while a bank is still open, the block asks for a precharge-all and waits. Each auto refresh is followed by a hold-off of the refresh cycle time. The block then retires one owed refresh and hands the bus back.

A host request to enter self refresh drives the refresh encoding with the clock enable low and clears the owed count. If the count has reached its ceiling, the owed refresh is performed first. While the device is in self refresh, the clock enable stays low. A host request to leave self refresh raises the clock enable and starts a fixed window of deselect cycles. Exactly one auto refresh follows that window before normal traffic resumes.

Top module: `ddr_refresh_seq`

## Requirements
- R1: After reset: `cke_o`=1, all of `cs_n_o`/`ras_n_o`/`cas_n_o`/`we_n_o`=1 (deselect), `state_o`=0, `pending_o`=0, `arb_req_o`=0, `urgent_o`=0.
- R2: `pending_o` rises by one after every `T_REFI` clock cycles spent in idle or refreshing. It saturates at `MAX_PEND` (8). In idle, `arb_req_o` is high whenever `pending_o` is non-zero.
- R3: `urgent_o` is high exactly when `pending_o` equals `MAX_PEND`.
- R4: A command is issued only in the cycle after `arb_gnt_i` and `banks_idle_i` were both high. While granted with a request pending and `banks_idle_i` low, `pre_all_o` is high and the pins stay at deselect.
- R5: An auto refresh is one cycle of pins {cke,cs_n,ras_n,cas_n,we_n}=5'b10001. It is followed by `T_RFC`-1 deselect cycles with `state_o`=1. On the next cycle `state_o`=0 and `pending_o` is one lower.
- R6: Self refresh entry is one cycle of pins 5'b00001, with `state_o`=2 and `pending_o`=0 from that cycle on. If `pending_o` equals `MAX_PEND` when entry is requested, an auto refresh is issued first. If `pending_o` is below `MAX_PEND`, entry happens directly.
- R7: While `state_o`=2, the pins are 5'b01111 (clock enable low, others high) every cycle, and `pending_o` stays 0.
- R8: A `sr_exit_i` pulse in self refresh raises `cke_o`. Exactly `T_XSR` (200) cycles of deselect then follow, with `state_o`=3.
- R9: The cycle after the exit window carries one auto refresh (5'b10001, `state_o`=1). After `T_RFC` cycles the block returns to `state_o`=0 with `pending_o`=0.
- R10: `state_o` encodes 0 idle, 1 refreshing, 2 in self refresh, 3 exiting.
- R11: `sr_exit_i` outside self refresh has no effect on `state_o` or on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_enter_i | input | 1 | Host request to enter self refresh (level) |
| sr_exit_i | input | 1 | Host request to leave self refresh |
| arb_gnt_i | input | 1 | Command bus grant from the arbiter |
| banks_idle_i | input | 1 | All banks are precharged |
| arb_req_o | output | 1 | Request for the command bus |
| urgent_o | output | 1 | Owed refresh count at its ceiling |
| pre_all_o | output | 1 | Asks the arbiter to precharge all banks |
| cke_o | output | 1 | Clock enable pin |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| state_o | output | 2 | Sequencer status |
| pending_o | output | $clog2(MAX_PEND+1) | Owed refresh count |

## Verification
The bench builds the block with `T_REFI`=40, `T_RFC`=6, `T_XSR`=200 and `MAX_PEND`=8. The short interval lets the owed count climb through every value up to saturation in a few hundred cycles. It also lets the bench predict each timer expiry from the number of elapsed cycles. The full 200-cycle exit window is kept, so the deselect cycles are checked one by one against their exact count. The short refresh cycle time allows a sweep over precharge delays of zero to three cycles, together with both the urgent and the non-urgent self refresh entry paths.

// File: rtl/ddr_refresh_pkg.sv
package ddr_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REF  = 2'd1,
    ST_SELF = 2'd2,
    ST_EXIT = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_DESEL   = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam ddr_cmd_t CMD_REF     = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam ddr_cmd_t CMD_SR_IN   = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam ddr_cmd_t CMD_SR_HOLD = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int T_REFI = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (T_REFI > 1) ? $clog2(T_REFI) : 1;
  localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int MAX_PEND = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dec_i,
  input  logic          clr_i,
  output logic [PW-1:0] pend_o,
  output logic          urgent_o,
  output logic          nz_o
);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

  logic [PW-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) begin
      pend_d = '0;
    end else if (tick_i && !dec_i) begin
      if (pend_q != PMAX) pend_d = pend_q + 1'b1;
    end else if (dec_i && !tick_i) begin
      if (pend_q != '0) pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o   = pend_q;
  assign urgent_o = (pend_q == PMAX);
  assign nz_o     = (pend_q != '0);
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import ddr_refresh_pkg::*;
#(
  parameter int T_RFC = 15,
  parameter int T_XSR = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  input  logic       arb_gnt_i,
  input  logic       banks_idle_i,
  input  logic       pend_nz_i,
  input  logic       urgent_i,
  output logic       arb_req_o,
  output logic       pre_all_o,
  output logic       dec_o,
  output logic       clr_o,
  output logic       run_o,
  output ddr_cmd_t   cmd_o,
  output seq_state_e state_o
);
  localparam int TMAX = (T_RFC > T_XSR) ? T_RFC : T_XSR;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] RFC_LD = TW'(T_RFC - 1);
  localparam logic [TW-1:0] XSR_LD = TW'(T_XSR - 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  ddr_cmd_t      cmd_q, cmd_d;
  logic          want;

  assign want = pend_nz_i | sr_enter_i;

  always_comb begin
    state_d   = state_q;
    timer_d   = timer_q;
    cmd_d     = CMD_DESEL;
    dec_o     = 1'b0;
    clr_o     = 1'b0;
    arb_req_o = 1'b1;
    pre_all_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        arb_req_o = want;
        pre_all_o = want & arb_gnt_i & ~banks_idle_i;
        if (want && arb_gnt_i && banks_idle_i) begin
          // an urgent backlog is served before self refresh entry
          if (sr_enter_i && !urgent_i) begin
            cmd_d   = CMD_SR_IN;
            state_d = ST_SELF;
            clr_o   = 1'b1;
          end else begin
            cmd_d   = CMD_REF;
            state_d = ST_REF;
            timer_d = RFC_LD;
          end
        end
      end
      ST_REF: begin
        if (timer_q == '0) begin
          state_d = ST_IDLE;
          dec_o   = 1'b1;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      ST_SELF: begin
        clr_o = 1'b1;
        cmd_d = CMD_SR_HOLD;
        if (sr_exit_i) begin
          cmd_d   = CMD_DESEL;
          state_d = ST_EXIT;
          timer_d = XSR_LD;
        end
      end
      ST_EXIT: begin
        clr_o = 1'b1;
        if (timer_q == '0) begin
          cmd_d   = CMD_REF;
          state_d = ST_REF;
          timer_d = RFC_LD;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      cmd_q   <= CMD_DESEL;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      cmd_q   <= cmd_d;
    end
  end

  assign run_o   = (state_q == ST_IDLE) || (state_q == ST_REF);
  assign cmd_o   = cmd_q;
  assign state_o = state_q;
endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import ddr_refresh_pkg::*;
#(
  parameter int T_REFI   = 1560,
  parameter int T_RFC    = 15,
  parameter int T_XSR    = 200,
  parameter int MAX_PEND = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sr_enter_i,
  input  logic                          sr_exit_i,
  input  logic                          arb_gnt_i,
  input  logic                          banks_idle_i,
  output logic                          arb_req_o,
  output logic                          urgent_o,
  output logic                          pre_all_o,
  output logic                          cke_o,
  output logic                          cs_n_o,
  output logic                          ras_n_o,
  output logic                          cas_n_o,
  output logic                          we_n_o,
  output logic [1:0]                    state_o,
  output logic [$clog2(MAX_PEND+1)-1:0] pending_o
);
  logic       tick, dec, clr, run, pend_nz;
  ddr_cmd_t   cmd;
  seq_state_e state;

  ref_interval_timer #(.T_REFI(T_REFI)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  ref_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .dec_i    (dec),
    .clr_i    (clr),
    .pend_o   (pending_o),
    .urgent_o (urgent_o),
    .nz_o     (pend_nz)
  );

  ref_seq_fsm #(.T_RFC(T_RFC), .T_XSR(T_XSR)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sr_enter_i   (sr_enter_i),
    .sr_exit_i    (sr_exit_i),
    .arb_gnt_i    (arb_gnt_i),
    .banks_idle_i (banks_idle_i),
    .pend_nz_i    (pend_nz),
    .urgent_i     (urgent_o),
    .arb_req_o    (arb_req_o),
    .pre_all_o    (pre_all_o),
    .dec_o        (dec),
    .clr_o        (clr),
    .run_o        (run),
    .cmd_o        (cmd),
    .state_o      (state)
  );

  assign cke_o   = cmd.cke;
  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign state_o = state;
endmodule

// File: rtl/ddr_refresh_seq_chk.sv
module ddr_refresh_seq_chk #(
  parameter int T_XSR    = 200,
  parameter int MAX_PEND = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arb_gnt_i,
  input logic          banks_idle_i,
  input logic          urgent_o,
  input logic          cke_o,
  input logic          cs_n_o,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          we_n_o,
  input logic [1:0]    state_o,
  input logic [PW-1:0] pending_o
);
  localparam int XW = $clog2(T_XSR + 2);

  logic [XW-1:0] exit_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             exit_cnt <= '0;
    else if (state_o == 2'd3) exit_cnt <= exit_cnt + 1'b1;
    else                     exit_cnt <= '0;
  end

  p_pend_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o <= PW'(MAX_PEND));

  p_urgent_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(urgent_o) |-> $past(pending_o) == PW'(MAX_PEND - 1));

  p_ref_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_n_o) && cke_o && $past(state_o) == 2'd0) |-> $past(arb_gnt_i && banks_idle_i));

  p_sre_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(arb_gnt_i && banks_idle_i));

  p_ref_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && cke_o) |=> cs_n_o);

  p_sre_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (pending_o == '0 && state_o == 2'd2 && !cs_n_o && !ras_n_o && !cas_n_o && we_n_o));

  p_self_cke_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> !cke_o);

  p_exit_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |-> (cke_o && cs_n_o));

  p_exit_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd3 && state_o != 2'd3) |-> exit_cnt == XW'(T_XSR));

  p_exit_ref_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd3 && state_o != 2'd3) |->
      (state_o == 2'd1 && cke_o && !cs_n_o && !ras_n_o && !cas_n_o && we_n_o));
endmodule

bind ddr_refresh_seq ddr_refresh_seq_chk #(.T_XSR(T_XSR), .MAX_PEND(MAX_PEND)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .arb_gnt_i    (arb_gnt_i),
  .banks_idle_i (banks_idle_i),
  .urgent_o     (urgent_o),
  .cke_o        (cke_o),
  .cs_n_o       (cs_n_o),
  .ras_n_o      (ras_n_o),
  .cas_n_o      (cas_n_o),
  .we_n_o       (we_n_o),
  .state_o      (state_o),
  .pending_o    (pending_o)
);

// File: tb/ddr_refresh_seq_bench.sv
module ddr_refresh_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_REFI   = 40;
  localparam int T_RFC    = 6;
  localparam int T_XSR    = 200;
  localparam int MAX_PEND = 8;
  localparam int PW = $clog2(MAX_PEND + 1);

  localparam logic [4:0] P_DESEL = 5'b11111;
  localparam logic [4:0] P_REF   = 5'b10001;
  localparam logic [4:0] P_SRE   = 5'b00001;
  localparam logic [4:0] P_HOLD  = 5'b01111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_enter = 1'b0, sr_exit = 1'b0, gnt = 1'b0, banks_idle = 1'b0;
  logic req, urgent, pre_all, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] state;
  logic [PW-1:0] pending;
  logic [4:0] pins;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pins = {cke, cs_n, ras_n, cas_n, we_n};

  ddr_refresh_seq #(
    .T_REFI(T_REFI), .T_RFC(T_RFC), .T_XSR(T_XSR), .MAX_PEND(MAX_PEND)
  ) u_ddr_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
    .arb_gnt_i(gnt), .banks_idle_i(banks_idle), .arb_req_o(req), .urgent_o(urgent),
    .pre_all_o(pre_all), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .state_o(state), .pending_o(pending)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_pend(input int n);
    for (int i = 0; i < 4 * T_REFI; i++) begin
      if (int'(pending) == n) break;
      step();
    end
  endtask

  task automatic refresh_cycle(input string tag);
    int bad;
    chk(pins == P_REF && state == 2'd1, {tag, " refresh pins R5"}, int'(pins), int'(P_REF));
    bad = 0;
    for (int i = 0; i < T_RFC - 1; i++) begin
      step();
      if (pins != P_DESEL || state != 2'd1) bad++;
    end
    chk(bad == 0, {tag, " rfc hold R5"}, bad, 0);
  endtask

  initial begin
    int bad;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    banks_idle = 1'b1;
    #1;
    chk(pins == P_DESEL, "R1 pins", int'(pins), int'(P_DESEL));
    chk(state == 2'd0 && pending == '0, "R1 state/pending", int'(state), 0);
    chk(!req && !urgent, "R1 req/urgent", int'({req, urgent}), 0);

    repeat (T_REFI - 1) step();
    chk(pending == 0, "R2 before first expiry", int'(pending), 0);
    step();
    chk(pending == 1, "R2 first expiry", int'(pending), 1);
    chk(req == 1'b1, "R2 request", int'(req), 1);
    repeat (2 * T_REFI) step();
    chk(pending == 3 && !urgent, "R2 three owed", int'(pending), 3);
    repeat (5 * T_REFI - 1) step();
    chk(pending == 7 && !urgent, "R3 below ceiling", int'({urgent, pending}), 7);
    step();
    chk(pending == 8 && urgent, "R3 at ceiling", int'({urgent, pending}), 24);
    repeat (2 * T_REFI) step();
    chk(pending == 8, "R2 saturation", int'(pending), 8);
    chk(pins == P_DESEL, "R4 no grant no command", int'(pins), int'(P_DESEL));

    // urgent backlog with self refresh request, banks busy for 3 cycles
    sr_enter = 1'b1; gnt = 1'b1; banks_idle = 1'b0;
    #1;
    chk(pre_all == 1'b1, "R4 precharge ask", int'(pre_all), 1);
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (pins != P_DESEL || state != 2'd0 || !pre_all) bad++;
    end
    chk(bad == 0, "R4 wait for banks", bad, 0);
    banks_idle = 1'b1;
    step();
    chk(cke == 1'b1, "R6 urgent refresh first", int'(pins), int'(P_REF));
    refresh_cycle("urgent");
    step();
    chk(state == 2'd0 && pending == 7, "R5 retire one", int'(pending), 7);
    step();
    chk(pins == P_SRE && state == 2'd2, "R6 entry pins", int'(pins), int'(P_SRE));
    chk(pending == 0, "R6 clear", int'(pending), 0);
    sr_enter = 1'b0;
    bad = 0;
    for (int i = 0; i < 3 * T_REFI; i++) begin
      step();
      if (pins != P_HOLD || state != 2'd2 || pending != 0) bad++;
    end
    chk(bad == 0, "R7 hold in self refresh R10 status 2", bad, 0);

    sr_exit = 1'b1;
    step();
    sr_exit = 1'b0;
    chk(pins == P_DESEL && state == 2'd3, "R8 exit start R10 status 3", int'(pins), int'(P_DESEL));
    bad = 0;
    for (int i = 0; i < T_XSR - 1; i++) begin
      step();
      if (pins != P_DESEL || state != 2'd3) bad++;
    end
    chk(bad == 0, "R8 exit window", bad, 0);
    step();
    chk(pins == P_REF && state == 2'd1, "R9 extra refresh R10 status 1", int'(pins), int'(P_REF));
    refresh_cycle("exit");
    step();
    chk(state == 2'd0 && pending == 0 && !req, "R9 back to idle", int'(state), 0);

    sr_exit = 1'b1;
    step();
    sr_exit = 1'b0;
    chk(state == 2'd0 && pins == P_DESEL, "R11 exit ignored", int'(pins), int'(P_DESEL));
    step();
    chk(state == 2'd0 && pins == P_DESEL, "R11 exit ignored later", int'(state), 0);

    for (int d = 0; d < 4; d++) begin
      gnt = 1'b0;
      wait_pend(1);
      chk(pending == 1, "R2 sweep owed", int'(pending), 1);
      banks_idle = 1'b0; gnt = 1'b1;
      bad = 0;
      for (int i = 0; i < d; i++) begin
        step();
        if (pins != P_DESEL || !pre_all) bad++;
      end
      chk(bad == 0, "R4 sweep busy banks", bad, 0);
      banks_idle = 1'b1;
      step();
      refresh_cycle("sweep");
      step();
      chk(state == 2'd0 && pending == 0 && !req, "R5 sweep retire", int'(pending), 0);
    end

    gnt = 1'b0;
    wait_pend(2);
    sr_enter = 1'b1; gnt = 1'b1; banks_idle = 1'b1;
    step();
    chk(pins == P_SRE && state == 2'd2 && pending == 0, "R6 direct entry", int'(pins), int'(P_SRE));
    sr_enter = 1'b0;
    step();
    sr_exit = 1'b1;
    step();
    sr_exit = 1'b0;
    for (int i = 0; i < T_XSR + 2 * T_RFC; i++) begin
      if (state == 2'd0) break;
      step();
    end
    chk(state == 2'd0 && cke, "R10 idle after exit", int'(state), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule